// File: doc/BRIEF.md
# Host-DSP Doorbell Mailbox

This block lets a host processor and a DSP core exchange short messages. Each direction has its own 32-bit doorbell word, with a BUSY flag that announces a new message and a DONE flag that reports completion. The remaining 30 bits carry message data. Larger payloads go in a shared mailbox RAM that both sides can reach. The host gets one interrupt line, fed by two separate sources: a DONE on the host-to-DSP doorbell, meaning the DSP has replied, and a BUSY on the DSP-to-host doorbell, meaning the DSP has sent a message. Each source has its own mask bit.

A typical exchange runs like this. The host places a payload in the mailbox and then rings the host-to-DSP doorbell with BUSY set. The DSP answers by setting DONE, which raises the interrupt. The host masks that source, handles the reply, clears DONE and unmasks. In the other direction, the DSP rings with BUSY. The host masks, handles the message, and then completes it with one write that clears BUSY and sets DONE. When the DSP-to-host word carries a panic signature, a panic output is raised, along with the byte address of the crash record.

Top module: `dbmb_top`

## Requirements
- R1: After reset, both doorbells and the mask are zero, and irq, panic and both read-data outputs are zero.
- R2: Reads have a latency of one cycle: read data shows on h_rdata or d_rdata one clock after the word address is sampled.
  - The address map: when address bit 10 is 1, the access goes to the mailbox and bits 9:0 select one of 1024 words.
  - Otherwise, word 0 is the host-to-DSP doorbell, word 1 is the DSP-to-host doorbell, word 2 is the interrupt status and word 3 is the interrupt mask.
  - Every other register address reads as zero.
- R3: Both ports can write mailbox words, and the other port can read them. Byte enable bit i covers data bits 8i+7:8i. When both ports write the same byte of the same word in one cycle, the host byte is stored.
- R4: Both ports can write either doorbell, byte by byte, with byte enables. When both write the same byte in one cycle, the host byte is stored. BUSY is bit 31 and DONE is bit 30.
- R5: Interrupt status is read-only, and host writes to it are ignored. Bit 0 is the DONE flag of the host-to-DSP doorbell, and bit 1 is the BUSY flag of the DSP-to-host doorbell. A read returns the flag values of the cycle in which the address is sampled.
- R6: Mask bit 0 suppresses the DONE source and mask bit 1 suppresses the BUSY source. The mask is written by the host through byte 0. The irq output in cycle t+1 equals (DONE and not mask0) or (BUSY and not mask1), taken at cycle t.
- R7: DSP writes to words 2 and 3 have no effect. DSP reads of words 2 and 3 return zero.
- R8: panic is high while the DSP-to-host word has BUSY set and (word AND 0x0FFF0000) equals 0x0DEA0000. panic_off equals the mailbox base (0x00040000 by default) plus bits 15:0 of the host-to-DSP doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wen | input | 1 | Host write strobe |
| h_addr | input | 11 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host byte enables |
| h_rdata | output | 32 | Host read data, one cycle after the address |
| d_wen | input | 1 | DSP write strobe |
| d_addr | input | 11 | DSP word address |
| d_wdata | input | 32 | DSP write data |
| d_be | input | 4 | DSP byte enables |
| d_rdata | output | 32 | DSP read data, one cycle after the address |
| irq | output | 1 | Host interrupt, registered |
| panic | output | 1 | DSP panic signature present |
| panic_off | output | 32 | Byte address of the panic record |

## Verification
The bench goes after several corner cases:
- Same-cycle collisions between the host and the DSP on a doorbell byte and on a mailbox word. A design that let the DSP win would lose the host's flag write.
- The one-cycle lag of irq behind a flag or mask change. A design that left the status unregistered would raise or drop irq a cycle early. One that latched the mask late would fire once after masking.
- Writes to the read-only status word, and DSP writes and reads of the mask and status words. A leak would change the mask or return nonzero data.
- A panic signature with BUSY clear, and a near-miss signature. Both must keep panic low.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  localparam int BUSY_POS = 31;
  localparam int DONE_POS = 30;

  typedef enum logic [1:0] {
    RSEL_H2D  = 2'd0,
    RSEL_D2H  = 2'd1,
    RSEL_STAT = 2'd2,
    RSEL_MASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dbmb_doorbell.sv
module dbmb_doorbell #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_we,
  input  logic [DW/8-1:0] h_be,
  input  logic [DW-1:0]   h_wd,
  input  logic            d_we,
  input  logic [DW/8-1:0] d_be,
  input  logic [DW-1:0]   d_wd,
  output logic [DW-1:0]   q
);
  localparam int BW = DW / 8;

  logic [DW-1:0] q_d, q_r;

  for (genvar g = 0; g < BW; g++) begin : g_byte
    logic en;
    assign en = (h_we && h_be[g]) || (d_we && d_be[g]);

    always_comb begin
      if (h_we && h_be[g])      q_d[g*8 +: 8] = h_wd[g*8 +: 8];
      else if (d_we && d_be[g]) q_d[g*8 +: 8] = d_wd[g*8 +: 8];
      else                      q_d[g*8 +: 8] = q_r[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r[g*8 +: 8] <= 8'h00;
      else if (en) q_r[g*8 +: 8] <= q_d[g*8 +: 8];
    end
  end

  assign q = q_r;

  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && d_we && h_be[BW-1] && d_be[BW-1]) |=> q_r[DW-1 -: 8] == $past(h_wd[DW-1 -: 8])); // R4
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_we && !d_we) |=> $stable(q_r)); // R4
endmodule

// File: rtl/dbmb_mbox_ram.sv
module dbmb_mbox_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     a_we,
  input  logic [DW/8-1:0]          a_be,
  input  logic [$clog2(DEPTH)-1:0] a_idx,
  input  logic [DW-1:0]            a_wd,
  output logic [DW-1:0]            a_q,
  input  logic                     b_we,
  input  logic [DW/8-1:0]          b_be,
  input  logic [$clog2(DEPTH)-1:0] b_idx,
  input  logic [DW-1:0]            b_wd,
  output logic [DW-1:0]            b_q
);
  localparam int BW = DW / 8;

  logic [DW-1:0] mem [DEPTH];

  // Port b is written first, so that a byte port a also writes in this cycle ends up holding port a's value.
  always_ff @(posedge clk) begin
    for (int i = 0; i < BW; i++) begin
      if (b_we && b_be[i]) mem[b_idx][i*8 +: 8] <= b_wd[i*8 +: 8];
    end
    for (int i = 0; i < BW; i++) begin
      if (a_we && a_be[i]) mem[a_idx][i*8 +: 8] <= a_wd[i*8 +: 8];
    end
    a_q <= mem[a_idx];
    b_q <= mem[b_idx];
  end
endmodule

// File: rtl/dbmb_irq.sv
module dbmb_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_flag,
  input  logic       busy_flag,
  input  logic       mask_we,
  input  logic [1:0] mask_wd,
  output logic [1:0] mask_q,
  output logic [1:0] status,
  output logic       irq_q
);
  logic [1:0] mask_r;
  logic       irq_d;

  assign status = {busy_flag, done_flag};

  always_comb irq_d = |(status & ~mask_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_r <= 2'b00;
    else if (mask_we) mask_r <= mask_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign mask_q = mask_r;

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_r == 2'b11) |=> !irq_q); // R6
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(done_flag || busy_flag)); // R6
endmodule

// File: rtl/dbmb_top.sv
module dbmb_top #(
  parameter int          DW          = 32,
  parameter int          MB_DEPTH    = 1024,
  parameter logic [31:0] PANIC_MASK  = 32'h0FFF_0000,
  parameter logic [31:0] PANIC_MAGIC = 32'h0DEA_0000,
  parameter logic [31:0] MBOX_BASE   = 32'h0004_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       h_wen,
  input  logic [$clog2(MB_DEPTH):0]  h_addr,
  input  logic [DW-1:0]              h_wdata,
  input  logic [DW/8-1:0]            h_be,
  output logic [DW-1:0]              h_rdata,
  input  logic                       d_wen,
  input  logic [$clog2(MB_DEPTH):0]  d_addr,
  input  logic [DW-1:0]              d_wdata,
  input  logic [DW/8-1:0]            d_be,
  output logic [DW-1:0]              d_rdata,
  output logic                       irq,
  output logic                       panic,
  output logic [DW-1:0]              panic_off
);
  import dbmb_pkg::*;

  localparam int IW = $clog2(MB_DEPTH);
  localparam int AW = IW + 1;
  localparam int BW = DW / 8;

  // decode
  logic     h_mb, d_mb, h_reg_ok, d_reg_ok;
  reg_sel_e h_sel, d_sel;

  assign h_mb     = h_addr[AW-1];
  assign d_mb     = d_addr[AW-1];
  assign h_sel    = reg_sel_e'(h_addr[1:0]);
  assign d_sel    = reg_sel_e'(d_addr[1:0]);
  assign h_reg_ok = !h_mb && (h_addr[AW-2:2] == '0);
  assign d_reg_ok = !d_mb && (d_addr[AW-2:2] == '0);

  logic [DW-1:0] h2d_q, d2h_q;
  logic [1:0]    mask_q, status;
  logic          mask_we;

  dbmb_doorbell #(.DW(DW)) u_h2d (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_wen && h_reg_ok && h_sel == RSEL_H2D), .h_be(h_be), .h_wd(h_wdata),
    .d_we(d_wen && d_reg_ok && d_sel == RSEL_H2D), .d_be(d_be), .d_wd(d_wdata),
    .q(h2d_q)
  );

  dbmb_doorbell #(.DW(DW)) u_d2h (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_wen && h_reg_ok && h_sel == RSEL_D2H), .h_be(h_be), .h_wd(h_wdata),
    .d_we(d_wen && d_reg_ok && d_sel == RSEL_D2H), .d_be(d_be), .d_wd(d_wdata),
    .q(d2h_q)
  );

  assign mask_we = h_wen && h_reg_ok && (h_sel == RSEL_MASK) && h_be[0];

  dbmb_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .done_flag(h2d_q[DONE_POS]), .busy_flag(d2h_q[BUSY_POS]),
    .mask_we(mask_we), .mask_wd(h_wdata[1:0]),
    .mask_q(mask_q), .status(status), .irq_q(irq)
  );

  logic [DW-1:0] h_ram_q, d_ram_q;

  dbmb_mbox_ram #(.DW(DW), .DEPTH(MB_DEPTH)) u_ram (
    .clk(clk),
    .a_we(h_wen && h_mb), .a_be(h_be), .a_idx(h_addr[IW-1:0]), .a_wd(h_wdata), .a_q(h_ram_q),
    .b_we(d_wen && d_mb), .b_be(d_be), .b_idx(d_addr[IW-1:0]), .b_wd(d_wdata), .b_q(d_ram_q)
  );

  // read path: next-state, then registers
  logic [DW-1:0] h_rd_d, h_rd_q, d_rd_d, d_rd_q;
  logic          h_mb_q, d_mb_q;

  always_comb begin
    h_rd_d = '0;
    if (h_reg_ok) begin
      unique case (h_sel)
        RSEL_H2D:  h_rd_d = h2d_q;
        RSEL_D2H:  h_rd_d = d2h_q;
        RSEL_STAT: h_rd_d = {{(DW-2){1'b0}}, status};
        RSEL_MASK: h_rd_d = {{(DW-2){1'b0}}, mask_q};
      endcase
    end
  end

  always_comb begin
    d_rd_d = '0;
    if (d_reg_ok && d_sel == RSEL_H2D) d_rd_d = h2d_q;
    if (d_reg_ok && d_sel == RSEL_D2H) d_rd_d = d2h_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rd_q <= '0;
      d_rd_q <= '0;
      h_mb_q <= 1'b0;
      d_mb_q <= 1'b0;
    end else begin
      h_rd_q <= h_rd_d;
      d_rd_q <= d_rd_d;
      h_mb_q <= h_mb;
      d_mb_q <= d_mb;
    end
  end

  assign h_rdata = h_mb_q ? h_ram_q : h_rd_q;
  assign d_rdata = d_mb_q ? d_ram_q : d_rd_q;

  // panic detection
  assign panic     = d2h_q[BUSY_POS] && ((d2h_q & PANIC_MASK) == PANIC_MAGIC);
  assign panic_off = MBOX_BASE + {{(DW-16){1'b0}}, h2d_q[15:0]};

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wen && h_reg_ok && h_sel == RSEL_STAT) |=> $stable(mask_q)); // R5
  AST_DSP_NO_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_mb && d_reg_ok && d_addr[1]) |=> d_rdata == '0); // R7
  AST_DSP_NO_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wen && !h_wen) |=> $stable(mask_q)); // R7
  AST_PANIC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    panic |-> d2h_q[BUSY_POS] && (d2h_q[27:16] == PANIC_MAGIC[27:16])); // R8
endmodule

// File: tb/dbmb_top_test.sv
module dbmb_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wen = 1'b0, d_wen = 1'b0;
  logic [10:0] h_addr = '0, d_addr = '0;
  logic [31:0] h_wdata = '0, d_wdata = '0;
  logic [3:0]  h_be = '0, d_be = '0;
  logic [31:0] h_rdata, d_rdata, panic_off;
  logic        irq, panic;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dbmb_top uut (
    .clk(clk), .rst_n(rst_n),
    .h_wen(h_wen), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be), .h_rdata(h_rdata),
    .d_wen(d_wen), .d_addr(d_addr), .d_wdata(d_wdata), .d_be(d_be), .d_rdata(d_rdata),
    .irq(irq), .panic(panic), .panic_off(panic_off)
  );

  // behavioural reference model
  logic [31:0] m_mem [1024];
  logic [31:0] m_h2d = '0, m_d2h = '0, m_hrd = '0, m_drd = '0;
  logic [1:0]  m_mask = '0;
  logic        m_irq = 1'b0;

  function automatic logic [31:0] m_read(input bit host, input logic [10:0] a);
    if (a[10]) return m_mem[a[9:0]];
    if (a[9:2] != 0) return 32'h0;
    case (a[1:0])
      2'd0: return m_h2d;
      2'd1: return m_d2h;
      2'd2: return host ? {30'h0, m_d2h[31], m_h2d[30]} : 32'h0;
      default: return host ? {30'h0, m_mask} : 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h2d = 0; m_d2h = 0; m_mask = 0; m_irq = 0; m_hrd = 0; m_drd = 0;
    end else begin
      m_hrd = m_read(1'b1, h_addr);
      m_drd = m_read(1'b0, d_addr);
      m_irq = (m_h2d[30] && !m_mask[0]) || (m_d2h[31] && !m_mask[1]);
      for (int b = 0; b < 4; b++) begin
        if (d_wen && d_addr[10] && d_be[b]) m_mem[d_addr[9:0]][b*8 +: 8] = d_wdata[b*8 +: 8];
        if (h_wen && h_addr[10] && h_be[b]) m_mem[h_addr[9:0]][b*8 +: 8] = h_wdata[b*8 +: 8];
        if (d_wen && d_addr == 11'd0 && d_be[b]) m_h2d[b*8 +: 8] = d_wdata[b*8 +: 8];
        if (h_wen && h_addr == 11'd0 && h_be[b]) m_h2d[b*8 +: 8] = h_wdata[b*8 +: 8];
        if (d_wen && d_addr == 11'd1 && d_be[b]) m_d2h[b*8 +: 8] = d_wdata[b*8 +: 8];
        if (h_wen && h_addr == 11'd1 && h_be[b]) m_d2h[b*8 +: 8] = h_wdata[b*8 +: 8];
      end
      if (h_wen && h_addr == 11'd3 && h_be[0]) m_mask = h_wdata[1:0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      chk("R2 host rdata", h_rdata, m_hrd);
      chk("R2 dsp rdata", d_rdata, m_drd);
      chk("R6 irq", {31'h0, irq}, {31'h0, m_irq});
      chk("R8 panic", {31'h0, panic},
          {31'h0, m_d2h[31] && ((m_d2h & 32'h0FFF_0000) == 32'h0DEA_0000)});
      chk("R8 panic_off", panic_off, 32'h0004_0000 + {16'h0, m_h2d[15:0]});
    end
  endtask

  task automatic hwr(input logic [10:0] a, input logic [31:0] dat, input logic [3:0] be);
    h_wen = 1'b1; h_addr = a; h_wdata = dat; h_be = be;
    tick();
    h_wen = 1'b0;
  endtask

  task automatic dwr(input logic [10:0] a, input logic [31:0] dat, input logic [3:0] be);
    d_wen = 1'b1; d_addr = a; d_wdata = dat; d_be = be;
    tick();
    d_wen = 1'b0;
  endtask

  task automatic hrd(input logic [10:0] a, output logic [31:0] dat);
    h_addr = a; tick(); dat = h_rdata;
  endtask

  task automatic drd(input logic [10:0] a, output logic [31:0] dat);
    d_addr = a; tick(); dat = d_rdata;
  endtask

  task automatic run_main();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 panic", {31'h0, panic}, 32'h0);
    chk("R1 h_rdata", h_rdata, 32'h0);
    chk("R1 d_rdata", d_rdata, 32'h0);
    hrd(11'd0, v); chk("R1 h2d", v, 32'h0);
    hrd(11'd1, v); chk("R1 d2h", v, 32'h0);
    hrd(11'd3, v); chk("R1 mask", v, 32'h0);

    // R3 fill mailbox from host, read back from DSP
    for (int i = 0; i < 1024; i++) hwr({1'b1, 10'(i)}, 32'hA500_0000 ^ (i * 32'h0001_0203), 4'hF);
    drd({1'b1, 10'd5}, v); chk("R3 dsp sees host word", v, 32'hA500_0000 ^ (5 * 32'h0001_0203));
    dwr({1'b1, 10'd7}, 32'h1122_3344, 4'b0101);
    hrd({1'b1, 10'd7}, v);
    chk("R3 byte enables", v, {8'hA5 ^ 8'h00, 8'h22, 8'h0E ^ 8'h00, 8'h44} & 32'hFF00_FF00 | 32'h0022_0044
        | ((32'hA500_0000 ^ (7 * 32'h0001_0203)) & 32'hFF00_FF00) & 32'h0);
    // collision: same word, host bytes win
    h_wen = 1'b1; h_addr = {1'b1, 10'd9}; h_wdata = 32'hAAAA_AAAA; h_be = 4'b0011;
    d_wen = 1'b1; d_addr = {1'b1, 10'd9}; d_wdata = 32'h5555_5555; d_be = 4'b0110;
    tick(); h_wen = 1'b0; d_wen = 1'b0;
    hrd({1'b1, 10'd9}, v);
    chk("R3 collision", v, {((32'hA500_0000 ^ (9 * 32'h0001_0203)) >> 24) & 32'hFF, 8'h55, 8'hAA, 8'hAA} & 32'hFFFF_FFFF);

    // host to DSP message and reply
    hwr(11'd0, 32'h8000_0123, 4'hF);
    drd(11'd0, v); chk("R4 dsp sees BUSY", v, 32'h8000_0123);
    dwr(11'd0, 32'h4000_0123, 4'hF);
    chk("R6 irq lags DONE", {31'h0, irq}, 32'h0);
    tick(); chk("R6 irq on DONE", {31'h0, irq}, 32'h1);
    hrd(11'd2, v); chk("R5 status DONE", v, 32'h1);
    hwr(11'd3, 32'h1, 4'h1);
    chk("R6 irq one cycle after mask", {31'h0, irq}, 32'h1);
    tick(); chk("R6 masked", {31'h0, irq}, 32'h0);
    hwr(11'd0, 32'h0, 4'hF);
    hwr(11'd3, 32'h0, 4'h1);
    tick(); chk("R6 quiet after ack", {31'h0, irq}, 32'h0);

    // DSP to host message, completed by host
    dwr(11'd1, 32'h8000_0055, 4'hF);
    tick(); chk("R6 irq on BUSY", {31'h0, irq}, 32'h1);
    hrd(11'd2, v); chk("R5 status BUSY", v, 32'h2);
    hwr(11'd3, 32'h2, 4'h1);
    hwr(11'd1, 32'h4000_0055, 4'hF);
    hrd(11'd1, v); chk("R4 completion word", v, 32'h4000_0055);
    hwr(11'd3, 32'h0, 4'h1);
    tick(); chk("R6 quiet after completion", {31'h0, irq}, 32'h0);

    // doorbell byte collision
    h_wen = 1'b1; h_addr = 11'd0; h_wdata = 32'hC1C2_C3C4; h_be = 4'b1001;
    d_wen = 1'b1; d_addr = 11'd0; d_wdata = 32'h0102_0304; d_be = 4'b1100;
    tick(); h_wen = 1'b0; d_wen = 1'b0;
    hrd(11'd0, v); chk("R4 host wins byte", v, 32'hC102_00C4);
    hwr(11'd0, 32'h0, 4'hF);

    // read-only status, DSP control accesses
    hwr(11'd2, 32'hFFFF_FFFF, 4'hF);
    hrd(11'd3, v); chk("R5 status write ignored", v, 32'h0);
    dwr(11'd3, 32'h3, 4'hF);
    hrd(11'd3, v); chk("R7 dsp mask write ignored", v, 32'h0);
    hwr(11'd3, 32'h2, 4'h1);
    drd(11'd3, v); chk("R7 dsp mask read zero", v, 32'h0);
    drd(11'd2, v); chk("R7 dsp status read zero", v, 32'h0);
    hrd(11'd6, v); chk("R2 unmapped reads zero", v, 32'h0);
    hwr(11'd3, 32'h0, 4'h1);

    // panic
    hwr(11'd0, 32'h0000_0120, 4'hF);
    dwr(11'd1, 32'h0DEA_0000, 4'hF);
    chk("R8 no panic without BUSY", {31'h0, panic}, 32'h0);
    dwr(11'd1, 32'h8DEB_0000, 4'hF);
    chk("R8 near miss", {31'h0, panic}, 32'h0);
    dwr(11'd1, 32'h8DEA_0007, 4'hF);
    chk("R8 panic raised", {31'h0, panic}, 32'h1);
    chk("R8 offset", panic_off, 32'h0004_0120);
    hwr(11'd1, 32'h4000_0000, 4'hF);

    // mixed traffic checked against the model each cycle
    for (int i = 0; i < 2000; i++) begin
      h_wen = 1'($urandom); d_wen = 1'($urandom);
      h_addr = ($urandom % 3 == 0) ? {1'b1, 10'($urandom % 16)} : 11'($urandom % 6);
      d_addr = ($urandom % 3 == 0) ? {1'b1, 10'($urandom % 16)} : 11'($urandom % 6);
      h_wdata = $urandom; d_wdata = $urandom;
      h_be = 4'($urandom); d_be = 4'($urandom);
      tick();
    end
    h_wen = 1'b0; d_wen = 1'b0;
    tick();
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule